// File: doc/BRIEF.md
# Alternating Trigger Injected Sequencer

This block hands out trigger events from a single source, which is owned by the master conversion engine, to a master and a slave engine in turn. Each accepted trigger converts exactly one injected channel. The first trigger goes to the master, the next to the slave, and the turn keeps swapping after that. Each engine walks its own injected channel list with its own pointer, so the master converts its entries 0, 1, 2, ... on triggers 1, 3, 5, ... and the slave converts its entries 0, 1, 2, ... on triggers 2, 4, 6, ....

Each engine is modelled as a start/done handshake. The block pulses a start request and presents the channel number. The engine later pulses done together with its result, and the block stores that result in the slot of that engine's injected result bank. When an engine finishes the last entry of its list, the block pulses that engine's group-complete flag and its pointer wraps to entry 0.

A trigger that arrives while a conversion is still outstanding is dropped and reported as an overrun. Both lists have the same length, so after both groups are complete the turn is back at the master's first entry.

Top module: `alt_inj_seq`

## Requirements
- R1: After reset, busy_o, both start outputs, both group-complete flags and ovr_o are 0. All result slots are 0, and m_chan_o shows entry 0 of m_list_i.
- R2: A trigger that is sampled while the block is idle produces a one-cycle start pulse in the next cycle, on exactly one engine. The first accepted trigger after reset goes to the master.
- R3: Accepted triggers go to the master, then the slave, then the master again, and so on. The turn swaps when the engine currently converting returns done.
- R4: Each engine's channel output shows entry k of its own list, where entry k occupies bits [k*CH_W +: CH_W]. k counts the conversions that engine has completed, modulo N_CH, and does not depend on the other engine.
- R5: When the engine currently converting returns done, its data is written to slot k of its own result bus, at bits [k*DATA_W +: DATA_W]. Every other slot keeps its value.
- R6: An engine's group-complete flag pulses for one cycle, in the cycle after the done for list entry N_CH-1, and is 0 at all other times.
- R7: After 2*N_CH accepted and completed triggers, the next trigger again targets the master at entry 0.
- R8: A trigger sampled while busy, including in the same cycle as the completing done, produces no start pulse and a one-cycle ovr_o pulse in the next cycle. The outstanding conversion still completes normally.
- R9: A done from the engine that is not converting, or a done while idle, changes no result slot, no pointer and not the turn.
- R10: busy_o is 1 from the cycle after an accepted trigger up to and including the cycle in which the matching done is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Trigger event, one cycle per event |
| m_list_i | input | N_CH*CH_W | Master injected channel list |
| s_list_i | input | N_CH*CH_W | Slave injected channel list |
| m_start_o | output | 1 | Master conversion start pulse |
| m_chan_o | output | CH_W | Channel for the master conversion |
| m_done_i | input | 1 | Master conversion done pulse |
| m_data_i | input | DATA_W | Master conversion result |
| s_start_o | output | 1 | Slave conversion start pulse |
| s_chan_o | output | CH_W | Channel for the slave conversion |
| s_done_i | input | 1 | Slave conversion done pulse |
| s_data_i | input | DATA_W | Slave conversion result |
| m_res_o | output | N_CH*DATA_W | Master injected result bank |
| s_res_o | output | N_CH*DATA_W | Slave injected result bank |
| m_eoc_o | output | 1 | Master group-complete pulse |
| s_eoc_o | output | 1 | Slave group-complete pulse |
| ovr_o | output | 1 | Dropped-trigger pulse |
| busy_o | output | 1 | A conversion is outstanding |

## Verification
A completing done and a new trigger can be sampled at the same clock edge. The bench provokes this by raising trig_i in the very cycle the master returns done. The block must drop that trigger, flag ovr_o and still store the master result. The next trigger must then reach the slave, which shows that the completion was handled and the drop did not move the turn.

// File: rtl/alt_inj_pkg.sv
package alt_inj_pkg;
  typedef enum logic {
    ENG_MST = 1'b0,
    ENG_SLV = 1'b1
  } eng_e;
endpackage

// File: rtl/alt_inj_turn.sv
module alt_inj_turn
  import alt_inj_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       trig_i,
  input  logic [1:0] done_i,
  output logic [1:0] start_o,
  output logic [1:0] fin_o,
  output logic       busy_o,
  output logic       ovr_o
);
  eng_e turn_q;
  logic busy_q, ovr_q;
  logic [1:0] start_q;
  logic accept, done_hit;

  assign accept   = trig_i && !busy_q;
  assign done_hit = busy_q && done_i[turn_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      turn_q  <= ENG_MST;
      busy_q  <= 1'b0;
      ovr_q   <= 1'b0;
      start_q <= '0;
    end else begin
      ovr_q   <= trig_i && busy_q;
      start_q <= accept ? (2'b01 << turn_q) : 2'b00;
      if (accept)        busy_q <= 1'b1;
      else if (done_hit) busy_q <= 1'b0;
      if (done_hit) turn_q <= (turn_q == ENG_MST) ? ENG_SLV : ENG_MST;
    end
  end

  assign fin_o   = done_hit ? (2'b01 << turn_q) : 2'b00;
  assign start_o = start_q;
  assign busy_o  = busy_q;
  assign ovr_o   = ovr_q;
endmodule

// File: rtl/alt_inj_lane.sv
module alt_inj_lane #(
  parameter int N_CH   = 4,
  parameter int CH_W   = 5,
  parameter int DATA_W = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_CH*CH_W-1:0]     list_i,
  input  logic                     fin_i,
  input  logic [DATA_W-1:0]        data_i,
  output logic [CH_W-1:0]          chan_o,
  output logic [N_CH*DATA_W-1:0]   res_o,
  output logic                     eoc_o
);
  localparam int PTR_W = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic [PTR_W-1:0] ptr_q;
  logic             eoc_q;
  logic             last;

  assign last   = (ptr_q == PTR_W'(N_CH - 1));
  assign chan_o = list_i[ptr_q*CH_W +: CH_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      eoc_q <= 1'b0;
    end else begin
      eoc_q <= fin_i && last;
      if (fin_i) ptr_q <= last ? '0 : ptr_q + 1'b1;
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              slot_q <= '0;
      else if (fin_i && ptr_q == PTR_W'(g))     slot_q <= data_i;
    end
    assign res_o[g*DATA_W +: DATA_W] = slot_q;
  end

  assign eoc_o = eoc_q;
endmodule

// File: rtl/alt_inj_seq.sv
module alt_inj_seq #(
  parameter int N_CH   = 4,
  parameter int CH_W   = 5,
  parameter int DATA_W = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   trig_i,
  input  logic [N_CH*CH_W-1:0]   m_list_i,
  input  logic [N_CH*CH_W-1:0]   s_list_i,
  output logic                   m_start_o,
  output logic [CH_W-1:0]        m_chan_o,
  input  logic                   m_done_i,
  input  logic [DATA_W-1:0]      m_data_i,
  output logic                   s_start_o,
  output logic [CH_W-1:0]        s_chan_o,
  input  logic                   s_done_i,
  input  logic [DATA_W-1:0]      s_data_i,
  output logic [N_CH*DATA_W-1:0] m_res_o,
  output logic [N_CH*DATA_W-1:0] s_res_o,
  output logic                   m_eoc_o,
  output logic                   s_eoc_o,
  output logic                   ovr_o,
  output logic                   busy_o
);
  logic [1:0] start_v, fin_v, eoc_v;
  logic [N_CH*CH_W-1:0]   list_a [2];
  logic [DATA_W-1:0]      data_a [2];
  logic [CH_W-1:0]        chan_a [2];
  logic [N_CH*DATA_W-1:0] res_a  [2];

  assign list_a[0] = m_list_i;
  assign list_a[1] = s_list_i;
  assign data_a[0] = m_data_i;
  assign data_a[1] = s_data_i;

  alt_inj_turn u_turn (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig_i),
    .done_i ({s_done_i, m_done_i}),
    .start_o(start_v),
    .fin_o  (fin_v),
    .busy_o (busy_o),
    .ovr_o  (ovr_o)
  );

  for (genvar e = 0; e < 2; e++) begin : g_lane
    alt_inj_lane #(.N_CH(N_CH), .CH_W(CH_W), .DATA_W(DATA_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .list_i (list_a[e]),
      .fin_i  (fin_v[e]),
      .data_i (data_a[e]),
      .chan_o (chan_a[e]),
      .res_o  (res_a[e]),
      .eoc_o  (eoc_v[e])
    );
  end

  assign m_start_o = start_v[0];
  assign s_start_o = start_v[1];
  assign m_chan_o  = chan_a[0];
  assign s_chan_o  = chan_a[1];
  assign m_res_o   = res_a[0];
  assign s_res_o   = res_a[1];
  assign m_eoc_o   = eoc_v[0];
  assign s_eoc_o   = eoc_v[1];
endmodule

// File: rtl/alt_inj_seq_chk.sv
module alt_inj_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic trig_i,
  input logic m_done_i,
  input logic s_done_i,
  input logic m_start_o,
  input logic s_start_o,
  input logic m_eoc_o,
  input logic s_eoc_o,
  input logic ovr_o,
  input logic busy_o
);
  // R2
  single_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({m_start_o, s_start_o}));
  // R2
  accept_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i && !busy_o |=> busy_o && (m_start_o || s_start_o));
  // R8
  drop_ovr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i && busy_o |=> ovr_o && !m_start_o && !s_start_o);
  // R10
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_start_o || s_start_o) |-> busy_o);
  // R10
  hold_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !m_done_i && !s_done_i |=> busy_o);
  // R6
  m_eoc_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_eoc_o |-> $past(m_done_i));
  // R6
  s_eoc_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_eoc_o |-> $past(s_done_i));
endmodule

bind alt_inj_seq alt_inj_seq_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .trig_i   (trig_i),
  .m_done_i (m_done_i),
  .s_done_i (s_done_i),
  .m_start_o(m_start_o),
  .s_start_o(s_start_o),
  .m_eoc_o  (m_eoc_o),
  .s_eoc_o  (s_eoc_o),
  .ovr_o    (ovr_o),
  .busy_o   (busy_o)
);

// File: tb/alt_inj_seq_test.sv
module alt_inj_seq_test;
  localparam int N_CH = 4, CH_W = 5, DATA_W = 12;

  typedef struct packed {
    logic        slv;
    logic [4:0]  ch;
    logic [11:0] dat;
    logic        eoc;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{1'b0, 5'd1,  12'h0A1, 1'b0},
    '{1'b1, 5'd11, 12'h0B1, 1'b0},
    '{1'b0, 5'd2,  12'h0A2, 1'b0},
    '{1'b1, 5'd12, 12'h0B2, 1'b0},
    '{1'b0, 5'd3,  12'h0A3, 1'b0},
    '{1'b1, 5'd13, 12'h0B3, 1'b0},
    '{1'b0, 5'd4,  12'h0A4, 1'b1},
    '{1'b1, 5'd14, 12'h0B4, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, trig = 1'b0;
  logic m_done = 1'b0, s_done = 1'b0;
  logic [DATA_W-1:0] m_data = '0, s_data = '0;
  logic [N_CH*CH_W-1:0] m_list = {5'd4, 5'd3, 5'd2, 5'd1};
  logic [N_CH*CH_W-1:0] s_list = {5'd14, 5'd13, 5'd12, 5'd11};
  logic m_start, s_start, m_eoc, s_eoc, ovr, busy;
  logic [CH_W-1:0] m_chan, s_chan;
  logic [N_CH*DATA_W-1:0] m_res, s_res;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  alt_inj_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig),
    .m_list_i(m_list), .s_list_i(s_list),
    .m_start_o(m_start), .m_chan_o(m_chan), .m_done_i(m_done), .m_data_i(m_data),
    .s_start_o(s_start), .s_chan_o(s_chan), .s_done_i(s_done), .s_data_i(s_data),
    .m_res_o(m_res), .s_res_o(s_res), .m_eoc_o(m_eoc), .s_eoc_o(s_eoc),
    .ovr_o(ovr), .busy_o(busy)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog all requirements act=%0d exp=<100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 starts", {m_start, s_start}, 0);
    chk("R1 flags", {m_eoc, s_eoc, ovr}, 0);
    chk("R1 results", {m_res, s_res}, 0);
    chk("R1 chan", m_chan, 1);

    // R2 R3 R4 R5 R6 table walk
    for (int i = 0; i < 8; i++) begin
      trig = 1'b1; tick(); trig = 1'b0;
      chk("R2 R3 start", {m_start, s_start}, TBL[i].slv ? 2'b01 : 2'b10);
      chk("R4 chan", TBL[i].slv ? s_chan : m_chan, TBL[i].ch);
      chk("R10 busy", busy, 1);
      if (TBL[i].slv) begin s_done = 1'b1; s_data = TBL[i].dat; end
      else begin m_done = 1'b1; m_data = TBL[i].dat; end
      tick(); m_done = 1'b0; s_done = 1'b0;
      chk("R6 eoc", TBL[i].slv ? {s_eoc, m_eoc} : {m_eoc, s_eoc}, {TBL[i].eoc, 1'b0});
      chk("R10 idle", busy, 0);
    end
    chk("R5 m_res", m_res, {12'h0A4, 12'h0A3, 12'h0A2, 12'h0A1});
    chk("R5 s_res", s_res, {12'h0B4, 12'h0B3, 12'h0B2, 12'h0B1});
    tick();
    chk("R6 eoc low", {m_eoc, s_eoc}, 0);

    // R7 wrap to master entry 0; R8 trigger in same cycle as done
    trig = 1'b1; tick(); trig = 1'b0;
    chk("R7 start", {m_start, s_start}, 2'b10);
    chk("R7 chan", m_chan, 1);
    m_done = 1'b1; m_data = 12'h5A5; trig = 1'b1;
    tick(); m_done = 1'b0; trig = 1'b0;
    chk("R8 ovr", ovr, 1);
    chk("R8 no start", {m_start, s_start}, 0);
    chk("R8 busy", busy, 0);
    chk("R5 slot0", m_res[11:0], 12'h5A5);
    tick();
    chk("R8 ovr pulse", ovr, 0);

    // R3 turn advanced despite drop; R9 stray dones
    trig = 1'b1; tick(); trig = 1'b0;
    chk("R3 slave", {m_start, s_start}, 2'b01);
    chk("R4 slave chan", s_chan, 11);
    m_done = 1'b1; m_data = 12'hFFF; tick(); m_done = 1'b0;
    chk("R9 busy", busy, 1);
    chk("R9 m_res", m_res, {12'h0A4, 12'h0A3, 12'h0A2, 12'h5A5});
    chk("R9 m_chan", m_chan, 2);
    s_done = 1'b1; s_data = 12'h3C3; tick(); s_done = 1'b0;
    chk("R10 done", busy, 0);
    s_done = 1'b1; s_data = 12'hEEE; tick(); s_done = 1'b0;
    chk("R9 idle s_res", s_res, {12'h0B4, 12'h0B3, 12'h0B2, 12'h3C3});
    chk("R9 s_chan", s_chan, 12);

    // R8 trigger while busy; R4 independent pointers
    trig = 1'b1; tick(); trig = 1'b0;
    chk("R9 turn", {m_start, s_start}, 2'b10);
    chk("R4 m chan", m_chan, 2);
    trig = 1'b1; tick(); trig = 1'b0;
    chk("R8 busy ovr", ovr, 1);
    chk("R8 busy nostart", {m_start, s_start}, 0);
    m_done = 1'b1; m_data = 12'h111; tick(); m_done = 1'b0;
    chk("R8 completes", m_res[23:12], 12'h111);
    trig = 1'b1; tick(); trig = 1'b0;
    chk("R4 s chan", s_chan, 12);
    chk("R3 slave2", {m_start, s_start}, 2'b01);
    s_done = 1'b1; tick(); s_done = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule